// File: doc/BRIEF.md
# Dual-Half XOR Prediction Memory Tester

This engine exercises a word-addressed region of a single-port memory, 64 bits per word. It splits the region into two halves of equal size. It fills both halves with the same address-derived data. It then runs a programmed number of bursts. Each burst has two passes. The first pass draws a fresh key and rewrites every word of both halves as its old value XORed with that key, one read-modify-write per word. The second pass reads every word and compares it with a predicted value.

The prediction has two terms. The first is an address-linear fill term, kept in a register that advances by a fixed increment per word, so the word loop needs no multiplier. The second is an accumulator that holds the XOR of all keys used so far. Because each half is checked against this prediction and not against the other half, a fault that lies in only one half is charged to that half alone. Each half has its own saturating mismatch counter.

Control is a start pulse, a one-cycle done pulse and a busy level. The region base, region length, fill seed and burst count are captured when the engine accepts start. The memory port is bytewise addressed, with a one-cycle synchronous read.

Top module: `xor_pred_tester`

## Requirements
- R1: After reset, busy, done and mem_en are low, and both mismatch counters read zero.
- R2: The half size is N = floor(region_len / 16) words. Half A starts at region_base and half B starts at region_base + 8N. No access falls outside [region_base, region_base + 16N), so with an odd word count the last word is left alone.
- R3: After the fill, word k of each half holds (region_base + 8k) * seed, taken modulo 2^64. Both halves hold the same value at the same offset.
- R4: The key for burst b is KEY_INIT advanced b times by a right-shift Galois step. The step shifts the state right by one and, when the bit shifted out is 1, XORs the result with 0xD800000000000000. Keys restart from KEY_INIT on every start. Each burst replaces every word of both halves with its old value XOR that key.
- R5: In each verify pass every word is compared with its fill value XOR the XOR of all keys used so far. A mismatch in half A increments err_a only, and a mismatch in half B increments err_b only. The counters never decrease during a run.
- R6: The verify pass only reads. A run makes exactly 2N(B+1) writes, where B is the burst count, and a word that fails a check is not rewritten by the check.
- R7: Each counter saturates at 2^ERR_W - 1.
- R8: With a burst count of zero the engine performs the fill only and reports zero mismatches. With N = 0 it raises done without touching the memory.
- R9: done is high for exactly one cycle per run. start, and any change of the configuration inputs, while busy is high are ignored. mem_en stays low whenever busy is low.
- R10: An accepted start clears both counters and the key accumulator, so results from one run do not carry into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| region_base | input | ADDR_W | Byte address of the region, 8-byte aligned |
| region_len | input | ADDR_W | Region length in bytes |
| fill_seed | input | DW | Multiplier for the fill data |
| burst_cnt | input | BW | Number of XOR/verify bursts |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_a | output | ERR_W | Saturating mismatch count, half A |
| err_b | output | ERR_W | Saturating mismatch count, half B |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write when set, read otherwise |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after a read |

## Verification
The bench first runs clean regions of several sizes and seeds, including a zero-burst run, a run with an odd word count and a run with N = 0. These runs separate errors in the fill arithmetic, the key sequence, the half offset and the region boundary. Each result is compared in full against a memory image computed in the bench.

Next, a stuck-at-one bit is placed first in half A and then in half B. The expected count is the number of bursts in which the predicted bit is zero. This shows that each half is charged independently and that prediction, not comparison between halves, drives the check. A fault covering all of half B pushes err_b into saturation.

Two further runs cover control behaviour. A mid-run start that also changes the configuration inputs shows that the captured configuration holds. A clean run after a faulty one shows that the counters and the accumulator are cleared.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL_A,
    ST_FILL_B,
    ST_MOD_RA,
    ST_MOD_WA,
    ST_MOD_RB,
    ST_MOD_WB,
    ST_VER_A,
    ST_VER_B,
    ST_VER_C,
    ST_DONE
  } xpt_state_e;
endpackage

// File: rtl/xpt_key_lfsr.sv
// Burst key source: Galois LFSR, reloaded on start, advanced once per burst.
module xpt_key_lfsr #(
  parameter int             DW   = 64,
  parameter logic [DW-1:0]  INIT = 64'h1D872B419C3E5F06,
  parameter logic [DW-1:0]  TAPS = 64'hD800000000000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  output logic [DW-1:0] key
);
  logic [DW-1:0] key_d;

  always_comb begin
    key_d = key;
    if (load)      key_d = INIT;
    else if (step) key_d = (key >> 1) ^ ({DW{key[0]}} & TAPS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            key <= INIT;
    else if (load || step) key <= key_d;
  end
endmodule

// File: rtl/xpt_sat_cnt.sv
// Saturating event counter with synchronous clear.
module xpt_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (inc && (cnt != {W{1'b1}}));
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/xor_pred_tester.sv
module xor_pred_tester
  import xpt_pkg::*;
#(
  parameter int            DW       = 64,
  parameter int            ADDR_W   = 12,
  parameter int            BW       = 8,
  parameter int            ERR_W    = 16,
  parameter logic [DW-1:0] KEY_INIT = 64'h1D872B419C3E5F06,
  parameter logic [DW-1:0] KEY_TAPS = 64'hD800000000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] region_base,
  input  logic [ADDR_W-1:0] region_len,
  input  logic [DW-1:0]     fill_seed,
  input  logic [BW-1:0]     burst_cnt,
  output logic              busy,
  output logic              done,
  output logic [ERR_W-1:0]  err_a,
  output logic [ERR_W-1:0]  err_b,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int WORD_BYTES = DW / 8;
  localparam int BYTE_SH    = $clog2(WORD_BYTES);

  xpt_state_e        state_q, state_d;
  logic [ADDR_W-1:0] k_q, k_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DW-1:0]     pred_q, pred_d;
  logic [DW-1:0]     acc_q, acc_d;
  logic [BW-1:0]     bleft_q, bleft_d;

  logic [ADDR_W-1:0] base_addr_q, n_q, off_q;
  logic [DW-1:0]     base_q, pincr_q;

  logic [ADDR_W-1:0] n_w;
  logic [DW-1:0]     base_w;
  logic [ADDR_W-1:0] addr_b;
  logic [DW-1:0]     expect_w;
  logic [DW-1:0]     key;
  logic              last;
  logic              cfg_ld, key_ld, key_step, cnt_clr;
  logic [1:0]        hit;
  logic [ERR_W-1:0]  cnt [2];

  assign n_w      = region_len >> (BYTE_SH + 1);
  assign base_w   = DW'(region_base) * fill_seed;
  assign addr_b   = addr_q + off_q;
  assign expect_w = pred_q ^ acc_q;
  assign last     = (k_q == n_q - 1'b1);

  // Next-state and datapath control
  always_comb begin
    state_d  = state_q;
    k_d      = k_q;
    addr_d   = addr_q;
    pred_d   = pred_q;
    acc_d    = acc_q;
    bleft_d  = bleft_q;
    cfg_ld   = 1'b0;
    key_ld   = 1'b0;
    key_step = 1'b0;
    cnt_clr  = 1'b0;
    hit      = 2'b00;
    mem_en   = 1'b0;
    mem_we   = 1'b0;
    mem_addr = addr_q;
    mem_wdata = pred_q;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          cfg_ld  = 1'b1;
          key_ld  = 1'b1;
          cnt_clr = 1'b1;
          acc_d   = '0;
          k_d     = '0;
          addr_d  = region_base;
          pred_d  = base_w;
          bleft_d = burst_cnt;
          state_d = (n_w == '0) ? ST_DONE : ST_FILL_A;
        end
      end
      ST_FILL_A: begin
        mem_en  = 1'b1;
        mem_we  = 1'b1;
        state_d = ST_FILL_B;
      end
      ST_FILL_B: begin
        mem_en   = 1'b1;
        mem_we   = 1'b1;
        mem_addr = addr_b;
        if (last) begin
          k_d     = '0;
          addr_d  = base_addr_q;
          pred_d  = base_q;
          state_d = (bleft_q == '0) ? ST_DONE : ST_MOD_RA;
        end else begin
          k_d     = k_q + 1'b1;
          addr_d  = addr_q + ADDR_W'(WORD_BYTES);
          pred_d  = pred_q + pincr_q;
          state_d = ST_FILL_A;
        end
      end
      ST_MOD_RA: begin
        mem_en  = 1'b1;
        state_d = ST_MOD_WA;
      end
      ST_MOD_WA: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = mem_rdata ^ key;
        state_d   = ST_MOD_RB;
      end
      ST_MOD_RB: begin
        mem_en   = 1'b1;
        mem_addr = addr_b;
        state_d  = ST_MOD_WB;
      end
      ST_MOD_WB: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = addr_b;
        mem_wdata = mem_rdata ^ key;
        if (last) begin
          k_d     = '0;
          addr_d  = base_addr_q;
          pred_d  = base_q;
          acc_d   = acc_q ^ key;
          state_d = ST_VER_A;
        end else begin
          k_d     = k_q + 1'b1;
          addr_d  = addr_q + ADDR_W'(WORD_BYTES);
          state_d = ST_MOD_RA;
        end
      end
      ST_VER_A: begin
        mem_en  = 1'b1;
        state_d = ST_VER_B;
      end
      ST_VER_B: begin
        mem_en   = 1'b1;
        mem_addr = addr_b;
        hit[0]   = (mem_rdata != expect_w);
        state_d  = ST_VER_C;
      end
      ST_VER_C: begin
        hit[1] = (mem_rdata != expect_w);
        if (last) begin
          k_d      = '0;
          addr_d   = base_addr_q;
          pred_d   = base_q;
          key_step = 1'b1;
          bleft_d  = bleft_q - 1'b1;
          state_d  = (bleft_q == BW'(1)) ? ST_DONE : ST_MOD_RA;
        end else begin
          k_d     = k_q + 1'b1;
          addr_d  = addr_q + ADDR_W'(WORD_BYTES);
          pred_d  = pred_q + pincr_q;
          state_d = ST_VER_A;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Run state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      addr_q  <= '0;
      pred_q  <= '0;
      acc_q   <= '0;
      bleft_q <= '0;
    end else begin
      state_q <= state_d;
      k_q     <= k_d;
      addr_q  <= addr_d;
      pred_q  <= pred_d;
      acc_q   <= acc_d;
      bleft_q <= bleft_d;
    end
  end

  // Configuration captured on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      n_q         <= '0;
      off_q       <= '0;
      base_q      <= '0;
      pincr_q     <= '0;
    end else if (cfg_ld) begin
      base_addr_q <= region_base;
      n_q         <= n_w;
      off_q       <= n_w << BYTE_SH;
      base_q      <= base_w;
      pincr_q     <= fill_seed << BYTE_SH;
    end
  end

  xpt_key_lfsr #(.DW(DW), .INIT(KEY_INIT), .TAPS(KEY_TAPS)) u_keys (
    .clk  (clk),
    .rst_n(rst_n),
    .load (key_ld),
    .step (key_step),
    .key  (key)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half_cnt
    xpt_sat_cnt #(.W(ERR_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cnt_clr),
      .inc  (hit[h]),
      .cnt  (cnt[h])
    );
  end

  assign err_a = cnt[0];
  assign err_b = cnt[1];
  assign busy  = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done  = (state_q == ST_DONE);
endmodule

// File: rtl/xpt_checker.sv
module xpt_checker #(
  parameter int ADDR_W = 12,
  parameter int ERR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] lo,
  input logic [ADDR_W-1:0] off,
  input logic [ERR_W-1:0]  err_a,
  input logic [ERR_W-1:0]  err_b
);
  logic [ADDR_W:0] a_ext, lo_ext, hi_ext;
  logic            accept;

  assign a_ext  = {1'b0, mem_addr};
  assign lo_ext = {1'b0, lo};
  assign hi_ext = lo_ext + {off, 1'b0};
  assign accept = start && !busy && !done;

  assert_addr_in_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (a_ext >= lo_ext) && (a_ext < hi_ext));

  assert_err_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (err_a >= $past(err_a)) && (err_b >= $past(err_b)));

  assert_count_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && ((err_a != $past(err_a)) || (err_b != $past(err_b)))) |-> !$past(mem_we));

  assert_we_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  assert_err_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_a == {ERR_W{1'b1}}) && !accept) |=> (err_a == {ERR_W{1'b1}}));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

  assert_clear_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (err_a == '0) && (err_b == '0));
endmodule

bind xor_pred_tester xpt_checker #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .mem_en  (mem_en),
  .mem_we  (mem_we),
  .mem_addr(mem_addr),
  .lo      (base_addr_q),
  .off     (off_q),
  .err_a   (err_a),
  .err_b   (err_b)
);

// File: tb/sim_xor_pred_tester.sv
`timescale 1ns/1ps
module sim_xor_pred_tester;
  localparam int          AW    = 10;
  localparam int          EW    = 4;
  localparam int          BWID  = 4;
  localparam int          WORDS = (1 << AW) / 8;
  localparam logic [63:0] KINIT = 64'h1D872B419C3E5F06;
  localparam logic [63:0] SENT  = 64'hA5A5_0000_0000_0000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] region_base, region_len;
  logic [63:0]   fill_seed;
  logic [BWID-1:0] burst_cnt;
  logic          busy, done, mem_en, mem_we;
  logic [EW-1:0] err_a, err_b;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata;

  logic [63:0] mem [WORDS];
  int          f_lo, f_hi;
  logic [63:0] f_mask;
  int          nchk = 0, nerr = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  xor_pred_tester #(.DW(64), .ADDR_W(AW), .BW(BWID), .ERR_W(EW), .KEY_INIT(KINIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .region_base(region_base),
    .region_len(region_len), .fill_seed(fill_seed), .burst_cnt(burst_cnt),
    .busy(busy), .done(done), .err_a(err_a), .err_b(err_b),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Single-port memory model with optional stuck-at-one bits on a word range
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (int'(mem_addr >> 3) >= f_lo && int'(mem_addr >> 3) < f_hi)
          mem[mem_addr >> 3] <= mem_wdata | f_mask;
        else
          mem[mem_addr >> 3] <= mem_wdata;
      end else begin
        mem_rdata <= mem[mem_addr >> 3];
      end
    end
  end

  function automatic logic [63:0] key_next(input logic [63:0] s);
    return (s >> 1) ^ (s[0] ? 64'hD800000000000000 : 64'h0);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input string req, input int base, input int len, input logic [63:0] seed,
                     input int bursts, input int flo, input int fhi, input logic [63:0] fmask,
                     input bit poke);
    int n, wr, cyc, ea, eb, bad;
    logic [63:0] acc, key, ideal, act;
    logic [63:0] expm [WORDS];
    for (int i = 0; i < WORDS; i++) mem[i] = SENT | 64'(i);
    f_lo = flo; f_hi = fhi; f_mask = fmask;
    region_base = AW'(base); region_len = AW'(len);
    fill_seed = seed; burst_cnt = BWID'(bursts);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wr = 0; cyc = 0;
    while (!done) begin
      if (mem_en && mem_we) wr++;
      if (poke && cyc == 5) begin
        start = 1'b1;
        region_base = AW'(base + 64);
        fill_seed = ~seed;
        burst_cnt = BWID'(1);
      end else begin
        start = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    // expected results from the requirements
    n = len / 16;
    acc = 64'h0; key = KINIT; ea = 0; eb = 0;
    for (int i = 0; i < WORDS; i++) expm[i] = SENT | 64'(i);
    for (int b = 0; b < bursts; b++) begin
      acc ^= key;
      for (int k = 0; k < n; k++) begin
        for (int h = 0; h < 2; h++) begin
          int w;
          w = base / 8 + k + h * n;
          ideal = ((64'(base) + 64'(8 * k)) * seed) ^ acc;
          act = (w >= flo && w < fhi) ? (ideal | fmask) : ideal;
          if (act != ideal) begin
            if (h == 0) ea++; else eb++;
          end
        end
      end
      key = key_next(key);
    end
    for (int k = 0; k < n; k++) begin
      for (int h = 0; h < 2; h++) begin
        int w;
        w = base / 8 + k + h * n;
        ideal = ((64'(base) + 64'(8 * k)) * seed) ^ acc;
        expm[w] = (w >= flo && w < fhi) ? (ideal | fmask) : ideal;
      end
    end
    if (ea > 15) ea = 15;
    if (eb > 15) eb = 15;
    chk(req, "err_a", 64'(err_a), 64'(ea));
    chk(req, "err_b", 64'(err_b), 64'(eb));
    chk("R6", "write count", 64'(wr), 64'(2 * n * (bursts + 1)));
    bad = 0;
    for (int i = 0; i < WORDS; i++) if (mem[i] !== expm[i]) bad++;
    chk(req, "memory image mismatching words", 64'(bad), 64'h0);
    @(negedge clk);
    chk("R9", "done single cycle", 64'(done), 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    region_base = '0; region_len = '0; fill_seed = '0; burst_cnt = '0;
    f_lo = 0; f_hi = 0; f_mask = 64'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", 64'(busy), 64'h0);
    chk("R1", "done", 64'(done), 64'h0);
    chk("R1", "mem_en", 64'(mem_en), 64'h0);
    chk("R1", "err_a", 64'(err_a), 64'h0);
    chk("R1", "err_b", 64'(err_b), 64'h0);
    // R3 R8: fill only
    run("R3", 64, 128, 64'h9E3779B97F4A7C15, 0, 0, 0, 64'h0, 1'b0);
    // R4 with an ignored mid-run start (R9)
    run("R4", 0, 256, 64'hC2B2AE3D27D4EB4F, 3, 0, 0, 64'h0, 1'b1);
    // R2: odd word count, last word untouched
    run("R2", 16, 200, 64'h165667B19E3779F9, 2, 0, 0, 64'h0, 1'b0);
    // R5: stuck bit in half A, then in half B
    run("R5", 128, 256, 64'h27D4EB2F165667C5, 6, 20, 21, 64'h20, 1'b0);
    run("R5", 128, 256, 64'h27D4EB2F165667C5, 6, 40, 41, 64'h0000_0100_0000_0001, 1'b0);
    // R7: all of half B stuck at ones, 24 mismatches saturate at 15
    run("R7", 512, 128, 64'h85EBCA77C2B2AE63, 3, 72, 80, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    // R8: empty region
    run("R8", 256, 8, 64'h1, 2, 0, 0, 64'h0, 1'b0);
    // R10: clean rerun after a faulty run clears counters and accumulator
    run("R5", 128, 256, 64'h27D4EB2F165667C5, 6, 20, 21, 64'h20, 1'b0);
    run("R10", 128, 256, 64'h27D4EB2F165667C5, 6, 0, 0, 64'h0, 1'b0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule